// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block watches the bytes an I2C slave receiver collects from the bus and decides, byte by byte, whether the current transfer is aimed at this device. It holds no shifter of its own. A receive shifter upstream hands it each completed byte together with markers that say whether the byte is the first after a start condition, and whether that start was a repeated one. A separate strobe reports a stop condition. For every byte the block returns a one-cycle response: whether to drive ACK, whether the byte completed an address match, whether it is write data for an addressed target, and which target owns the transfer.

Two slave addresses can be programmed, each enabled on its own and each set to 7-bit or 10-bit form. The general call address is handled separately. One enable covers general calls issued by the chip's own master, and another covers calls from masters elsewhere on the bus. A sideband input tells the block which kind of master is driving the current transfer. After the address phase, write bytes are tagged for their target, and each is acknowledged only if the write-ACK enable for that target is set. A 10-bit read is accepted only through a repeated start after a full 10-bit write match.

Top module: `i2c_slave_addr_match`

## Requirements
- R1: While reset is held and after its release, before any byte arrives, every output is 0.
- R2: Each byte strobe (byteValid with stopIn low) yields respValid=1 exactly one cycle later. In that cycle firstFlag equals startMark and rptFlag equals startMark AND rptMark. A stopIn pulse yields stopFlag=1 one cycle later with respValid=0, and the block returns to waiting for a start.
- R3: decodeCtl bit 2 enables address 1, bit 4 enables address 2, and bits 3 and 5 select 10-bit form for them. In 7-bit form, a start byte whose bits [7:1] equal the stored bits [6:0] is a match. A match gives ackOut=1, addrHit=1, readDir=byte bit 0, and tgtSel one-hot: bit 0 for address 1, bit 1 for address 2.
- R4: A disabled address never matches. A start byte that matches nothing gets no ACK, and later bytes up to the next start get no ACK and no dataHit.
- R5: 10-bit write: a start byte 11110,a[9:8],0 for an enabled 10-bit address gets ACK with addrHit=0. The next byte gets ackOut=1 and addrHit=1 only if it equals a[7:0]; otherwise it gets no ACK and the transfer is ignored.
- R6: 10-bit read: a start byte 11110,a[9:8],1 matches (addrHit=1, readDir=1) only when it follows a repeated start and the same address was fully matched since the last stop or non-repeated start.
- R7: A start byte of 0x00 is a general call. It is acknowledged with gcHit=1 and tgtSel=0 when decodeCtl bit 0 is set and fromLocal=1, or when bit 1 is set and fromLocal=0. A byte 0x01 after a start is never a general call.
- R8: If both addresses match the same byte, address 1 is reported. A match on a programmed address is reported instead of a general call.
- R9: After a write match, each following byte has dataHit=1 and the same tgtSel and gcHit as the address phase. ackOut is rxCtl bit 0 for address 1, bit 1 for address 2, and bit 2 for a general call.
- R10: After a read match, received bytes get no ACK and no dataHit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A received byte is presented this cycle |
| byteData | input | 8 | Received byte |
| startMark | input | 1 | Byte is the first after a start condition |
| rptMark | input | 1 | That start was a repeated start |
| stopIn | input | 1 | Stop condition seen |
| fromLocal | input | 1 | Current transfer comes from the chip's own master |
| decodeCtl | input | 6 | Address decode enables and modes (bit map in R3, R7) |
| rxCtl | input | 3 | Write-data ACK enables (bit map in R9) |
| ownAddr1 | input | 10 | Slave address 1 (7-bit form uses bits [6:0]) |
| ownAddr2 | input | 10 | Slave address 2 |
| respValid | output | 1 | Response for the previous byte is valid |
| ackOut | output | 1 | Drive ACK for that byte |
| addrHit | output | 1 | Byte completed an address match |
| dataHit | output | 1 | Byte is write data for the addressed target |
| tgtSel | output | 2 | One-hot owning address |
| gcHit | output | 1 | Transfer is a general call |
| readDir | output | 1 | Matched transfer is a read |
| firstFlag | output | 1 | Byte followed a start |
| rptFlag | output | 1 | Byte followed a repeated start |
| stopFlag | output | 1 | Stop condition reported |

## Verification
The bench sweeps every byte value as a 7-bit start byte and as the low byte of a 10-bit address. A compare with the wrong bit slice would then acknowledge a stray address or miss the real one. It walks the 10-bit read rule through repeated, non-repeated and post-stop starts. A design that forgot the earlier full match would answer a bare read header, and one that kept the match across a fresh start would answer a stale read. The general-call test covers every combination of the two enables, the traffic origin and the write-data ACK bits. A swapped enable would acknowledge calls from the wrong master. Address priority gets its own tests, and read-addressed data bytes are checked for no ACK.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int SLOTS  = 2;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TENWAIT, ST_WRITE, ST_READ, ST_IGNORE
  } matchState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             loadCand;
    logic             takeSel;
    logic [SLOTS-1:0] selVal;
    logic             gcVal;
    logic             markTen;
    logic             clrTen;
  } dpStrobe_t;

  // datapath -> control compare results and held state
  typedef struct packed {
    logic [SLOTS-1:0] full7;
    logic [SLOTS-1:0] preWr;
    logic [SLOTS-1:0] preRd;
    logic [SLOTS-1:0] lowHit;
    logic [SLOTS-1:0] selReg;
    logic             gcReg;
  } dpView_t;

  function automatic logic [SLOTS-1:0] firstOne(input logic [SLOTS-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/addr_match_dp.sv
module addr_match_dp
  import addr_match_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [BYTE_W-1:0]            byteData,
  input  logic                         rptMark,
  input  logic [2*SLOTS-1:0]           slotCtl,
  input  logic [SLOTS-1:0][ADDR_W-1:0] addrTbl,
  input  dpStrobe_t                    stb,
  output dpView_t                      view
);
  localparam logic [4:0] TEN_HDR = 5'b11110;

  logic [SLOTS-1:0] full7, preWr, preRd, lowHit;
  logic [SLOTS-1:0] cand, tenSeen, selReg;
  logic             gcReg;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic slotEn, slotTen, hdrOk;
    assign slotEn  = slotCtl[2*k];
    assign slotTen = slotCtl[2*k+1];
    assign hdrOk   = (byteData[7:3] == TEN_HDR) && (byteData[2:1] == addrTbl[k][9:8]);
    assign full7[k]  = slotEn && !slotTen && (byteData[7:1] == addrTbl[k][6:0]);
    assign preWr[k]  = slotEn && slotTen && hdrOk && !byteData[0];
    assign preRd[k]  = slotEn && slotTen && hdrOk && byteData[0] && rptMark && tenSeen[k];
    assign lowHit[k] = cand[k] && (byteData == addrTbl[k][7:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cand    <= '0;
      tenSeen <= '0;
      selReg  <= '0;
      gcReg   <= 1'b0;
    end else begin
      if (stb.loadCand) cand <= preWr;
      tenSeen <= (stb.clrTen ? '0 : tenSeen) | (stb.markTen ? stb.selVal : '0);
      if (stb.takeSel) begin
        selReg <= stb.selVal;
        gcReg  <= stb.gcVal;
      end
    end
  end

  assign view = '{full7: full7, preWr: preWr, preRd: preRd, lowHit: lowHit,
                  selReg: selReg, gcReg: gcReg};

  // R6
  ten_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((tenSeen & ~$past(tenSeen)) != '0) |-> $past(stb.markTen));
endmodule

// File: rtl/addr_match_ctl.sv
module addr_match_ctl
  import addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              startMark,
  input  logic              rptMark,
  input  logic              stopIn,
  input  logic              fromLocal,
  input  logic              gcLocalEn,
  input  logic              gcExtEn,
  input  logic [2:0]        rxCtl,
  input  dpView_t           view,
  output dpStrobe_t         stb,
  output logic              respValid,
  output logic              ackOut,
  output logic              addrHit,
  output logic              dataHit,
  output logic [SLOTS-1:0]  tgtSel,
  output logic              gcHit,
  output logic              readDir,
  output logic              firstFlag,
  output logic              rptFlag,
  output logic              stopFlag
);
  matchState_e state, nxt;
  logic ackN, addrN, dataN, gcN, rdN;
  logic [SLOTS-1:0] selN;
  logic gcOk, takeByte;

  assign gcOk     = fromLocal ? gcLocalEn : gcExtEn;
  assign takeByte = byteValid && !stopIn;

  always_comb begin
    stb   = '0;
    nxt   = state;
    ackN  = 1'b0;
    addrN = 1'b0;
    dataN = 1'b0;
    gcN   = 1'b0;
    rdN   = 1'b0;
    selN  = '0;
    if (stopIn) begin
      nxt        = ST_IDLE;
      stb.clrTen = 1'b1;
    end else if (byteValid && startMark) begin
      stb.clrTen = !rptMark;
      if (|view.full7) begin
        selN = firstOne(view.full7);
        ackN = 1'b1; addrN = 1'b1; rdN = byteData[0];
        stb.takeSel = 1'b1; stb.selVal = selN;
        nxt = byteData[0] ? ST_READ : ST_WRITE;
      end else if (|view.preRd) begin
        selN = firstOne(view.preRd);
        ackN = 1'b1; addrN = 1'b1; rdN = 1'b1;
        stb.takeSel = 1'b1; stb.selVal = selN;
        nxt = ST_READ;
      end else if (|view.preWr) begin
        stb.loadCand = 1'b1;
        ackN = 1'b1;
        nxt  = ST_TENWAIT;
      end else if (byteData == '0 && gcOk) begin
        ackN = 1'b1; addrN = 1'b1; gcN = 1'b1;
        stb.takeSel = 1'b1; stb.gcVal = 1'b1;
        nxt = ST_WRITE;
      end else begin
        nxt = ST_IGNORE;
      end
    end else if (byteValid) begin
      unique case (state)
        ST_TENWAIT: begin
          if (|view.lowHit) begin
            selN = firstOne(view.lowHit);
            ackN = 1'b1; addrN = 1'b1;
            stb.takeSel = 1'b1; stb.selVal = selN; stb.markTen = 1'b1;
            nxt = ST_WRITE;
          end else begin
            nxt = ST_IGNORE;
          end
        end
        ST_WRITE: begin
          dataN = 1'b1;
          selN  = view.selReg;
          gcN   = view.gcReg;
          ackN  = view.gcReg ? rxCtl[2] : |(view.selReg & rxCtl[1:0]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      respValid <= 1'b0;
      ackOut    <= 1'b0;
      addrHit   <= 1'b0;
      dataHit   <= 1'b0;
      tgtSel    <= '0;
      gcHit     <= 1'b0;
      readDir   <= 1'b0;
      firstFlag <= 1'b0;
      rptFlag   <= 1'b0;
      stopFlag  <= 1'b0;
    end else begin
      state     <= nxt;
      respValid <= takeByte;
      ackOut    <= ackN;
      addrHit   <= addrN;
      dataHit   <= dataN;
      tgtSel    <= selN;
      gcHit     <= gcN;
      readDir   <= rdN;
      firstFlag <= takeByte && startMark;
      rptFlag   <= takeByte && startMark && rptMark;
      stopFlag  <= stopIn;
    end
  end

  // R2
  resp_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(byteValid));
  // R2
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopFlag |-> !respValid);
  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tgtSel));
  // R7
  gc_nosel_chk: assert property (@(posedge clk) disable iff (!rstN)
    gcHit |-> (tgtSel == '0));
  // R9
  data_not_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataHit |-> (!addrHit && !firstFlag));
  // R10
  idle_noack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !firstFlag && !dataHit && !addrHit) |-> !ackOut);
endmodule

// File: rtl/i2c_slave_addr_match.sv
module i2c_slave_addr_match
  import addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              startMark,
  input  logic              rptMark,
  input  logic              stopIn,
  input  logic              fromLocal,
  input  logic [5:0]        decodeCtl,
  input  logic [2:0]        rxCtl,
  input  logic [ADDR_W-1:0] ownAddr1,
  input  logic [ADDR_W-1:0] ownAddr2,
  output logic              respValid,
  output logic              ackOut,
  output logic              addrHit,
  output logic              dataHit,
  output logic [SLOTS-1:0]  tgtSel,
  output logic              gcHit,
  output logic              readDir,
  output logic              firstFlag,
  output logic              rptFlag,
  output logic              stopFlag
);
  dpStrobe_t stb;
  dpView_t   view;
  logic [SLOTS-1:0][ADDR_W-1:0] addrTbl;

  assign addrTbl = {ownAddr2, ownAddr1};

  addr_match_dp u_dp (
    .clk(clk), .rstN(rstN), .byteData(byteData), .rptMark(rptMark),
    .slotCtl(decodeCtl[5:2]), .addrTbl(addrTbl), .stb(stb), .view(view)
  );

  addr_match_ctl u_ctl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .startMark(startMark), .rptMark(rptMark), .stopIn(stopIn),
    .fromLocal(fromLocal), .gcLocalEn(decodeCtl[0]), .gcExtEn(decodeCtl[1]),
    .rxCtl(rxCtl), .view(view), .stb(stb),
    .respValid(respValid), .ackOut(ackOut), .addrHit(addrHit),
    .dataHit(dataHit), .tgtSel(tgtSel), .gcHit(gcHit), .readDir(readDir),
    .firstFlag(firstFlag), .rptFlag(rptFlag), .stopFlag(stopFlag)
  );
endmodule

// File: tb/i2c_slave_addr_match_tb.sv
module i2c_slave_addr_match_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0, startMark = 1'b0, rptMark = 1'b0, stopIn = 1'b0;
  logic fromLocal = 1'b0;
  logic [7:0] byteData = '0;
  logic [5:0] decodeCtl = '0;
  logic [2:0] rxCtl = '0;
  logic [9:0] ownAddr1 = '0, ownAddr2 = '0;
  logic respValid, ackOut, addrHit, dataHit, gcHit, readDir, firstFlag, rptFlag, stopFlag;
  logic [1:0] tgtSel;

  int nChk = 0, nErr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_slave_addr_match dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .startMark(startMark), .rptMark(rptMark), .stopIn(stopIn),
    .fromLocal(fromLocal), .decodeCtl(decodeCtl), .rxCtl(rxCtl),
    .ownAddr1(ownAddr1), .ownAddr2(ownAddr2), .respValid(respValid),
    .ackOut(ackOut), .addrHit(addrHit), .dataHit(dataHit), .tgtSel(tgtSel),
    .gcHit(gcHit), .readDir(readDir), .firstFlag(firstFlag), .rptFlag(rptFlag),
    .stopFlag(stopFlag)
  );

  // {respValid, ack, addrHit, dataHit, gcHit, tgtSel[1:0], readDir, first, rpt}
  function automatic logic [9:0] mk(logic rv, logic a, logic h, logic d, logic g,
                                    logic [1:0] s, logic rd, logic f, logic r);
    return {rv, a, h, d, g, s, rd, f, r};
  endfunction

  function automatic logic [9:0] got();
    return {respValid, ackOut, addrHit, dataHit, gcHit, tgtSel, readDir, firstFlag, rptFlag};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // all tasks start just after a falling edge and end just after the next one
  task automatic sendByte(logic [7:0] d, logic st, logic rp);
    byteData = d; startMark = st; rptMark = rp; byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0; startMark = 1'b0; rptMark = 1'b0;
  endtask

  task automatic sendStop();
    stopIn = 1'b1;
    @(negedge clk);
    stopIn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic m1, m2, wr, acc;
    logic [1:0] sel;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {got(), stopFlag}, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", {got(), stopFlag}, '0);

    // R3/R4/R9/R10 sweep of every 7-bit start byte
    decodeCtl = 6'b010100; ownAddr1 = 10'h02A; ownAddr2 = 10'h055; rxCtl = 3'b011;
    for (int b = 0; b < 256; b++) begin
      sendStop();
      if (b == 0) chk("R2", {stopFlag, respValid}, 2'b10);
      sendByte(b[7:0], 1'b1, 1'b0);
      m1 = (b[7:1] == 7'h2A); m2 = (b[7:1] == 7'h55);
      sel = m1 ? 2'b01 : (m2 ? 2'b10 : 2'b00);
      chk("R3", got(), mk(1, m1|m2, m1|m2, 0, 0, sel, (m1|m2) & b[0], 1, 0));
      sendByte(8'h33, 1'b0, 1'b0);
      wr = (m1|m2) & !b[0];
      chk(wr ? "R9" : ((m1|m2) ? "R10" : "R4"), got(), mk(1, wr, 0, wr, 0, wr ? sel : 2'b00, 0, 0, 0));
    end

    // R4 disabled addresses
    decodeCtl = 6'b000100;
    sendStop(); sendByte(8'hAA, 1'b1, 1'b0);
    chk("R4", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 0));
    decodeCtl = 6'b010000;
    sendStop(); sendByte(8'h54, 1'b1, 1'b0);
    chk("R4", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 0));
    sendStop(); sendByte(8'hAA, 1'b1, 1'b0);
    chk("R4", got(), mk(1, 1, 1, 0, 0, 2'b10, 0, 1, 0));

    // R8 priority
    decodeCtl = 6'b010100; ownAddr1 = 10'h02A; ownAddr2 = 10'h02A;
    sendStop(); sendByte(8'h54, 1'b1, 1'b0);
    chk("R8", got(), mk(1, 1, 1, 0, 0, 2'b01, 0, 1, 0));
    decodeCtl = 6'b000111; ownAddr1 = 10'h000; fromLocal = 1'b1;
    sendStop(); sendByte(8'h00, 1'b1, 1'b0);
    chk("R8", got(), mk(1, 1, 1, 0, 0, 2'b01, 0, 1, 0));
    decodeCtl = 6'b111100; ownAddr1 = 10'h2A5; ownAddr2 = 10'h2A5;
    sendStop(); sendByte(8'hF4, 1'b1, 1'b0); sendByte(8'hA5, 1'b0, 1'b0);
    chk("R8", got(), mk(1, 1, 1, 0, 0, 2'b01, 0, 0, 0));

    // R7 general call: enables x origin x data ACK bit
    for (int d = 0; d < 4; d++)
      for (int fl = 0; fl < 2; fl++)
        for (int rx = 0; rx < 8; rx++) begin
          decodeCtl = {4'b0000, d[1:0]}; fromLocal = fl[0]; rxCtl = rx[2:0];
          acc = fl[0] ? d[0] : d[1];
          sendStop(); sendByte(8'h00, 1'b1, 1'b0);
          chk("R7", got(), mk(1, acc, acc, 0, acc, 2'b00, 0, 1, 0));
          sendByte(8'h5A, 1'b0, 1'b0);
          chk("R9", got(), mk(1, acc & rx[2], 0, acc, acc, 2'b00, 0, 0, 0));
        end
    decodeCtl = 6'b000011;
    sendStop(); sendByte(8'h01, 1'b1, 1'b0);
    chk("R7", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 0));

    // R9 data ACK per target
    decodeCtl = 6'b010100; ownAddr1 = 10'h02A; ownAddr2 = 10'h055; fromLocal = 1'b0;
    for (int rx = 0; rx < 8; rx++)
      for (int t = 0; t < 2; t++) begin
        rxCtl = rx[2:0];
        sendStop(); sendByte(t ? 8'hAA : 8'h54, 1'b1, 1'b0);
        for (int n = 0; n < 2; n++) begin
          sendByte(8'hC0 + 8'(n), 1'b0, 1'b0);
          chk("R9", got(), mk(1, t ? rx[1] : rx[0], 0, 1, 0, t ? 2'b10 : 2'b01, 0, 0, 0));
        end
      end

    // R5 10-bit write, sweep of the low byte
    decodeCtl = 6'b111100; ownAddr1 = 10'h2A5; ownAddr2 = 10'h1C3; rxCtl = 3'b011;
    for (int b = 0; b < 256; b++) begin
      sendStop(); sendByte(8'hF4, 1'b1, 1'b0);
      if (b < 4) chk("R5", got(), mk(1, 1, 0, 0, 0, 2'b00, 0, 1, 0));
      sendByte(b[7:0], 1'b0, 1'b0);
      m1 = (b == 8'hA5);
      chk("R5", got(), mk(1, m1, m1, 0, 0, m1 ? 2'b01 : 2'b00, 0, 0, 0));
      sendByte(8'h11, 1'b0, 1'b0);
      chk(m1 ? "R9" : "R5", got(), mk(1, m1, 0, m1, 0, m1 ? 2'b01 : 2'b00, 0, 0, 0));
    end
    sendStop(); sendByte(8'hF2, 1'b1, 1'b0); sendByte(8'hC3, 1'b0, 1'b0);
    chk("R5", got(), mk(1, 1, 1, 0, 0, 2'b10, 0, 0, 0));
    sendStop(); sendByte(8'hF6, 1'b1, 1'b0);
    chk("R5", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 0));
    ownAddr2 = 10'h2C3;
    sendStop(); sendByte(8'hF4, 1'b1, 1'b0); sendByte(8'hC3, 1'b0, 1'b0);
    chk("R5", got(), mk(1, 1, 1, 0, 0, 2'b10, 0, 0, 0));
    ownAddr2 = 10'h1C3;

    // R6 10-bit read after repeated start
    sendStop(); sendByte(8'hF4, 1'b1, 1'b0); sendByte(8'hA5, 1'b0, 1'b0);
    sendByte(8'hF5, 1'b1, 1'b1);
    chk("R6", got(), mk(1, 1, 1, 0, 0, 2'b01, 1, 1, 1));
    sendByte(8'h11, 1'b0, 1'b0);
    chk("R10", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 0, 0));
    sendStop(); sendByte(8'hF5, 1'b1, 1'b1);
    chk("R6", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 1));
    sendStop(); sendByte(8'hF4, 1'b1, 1'b0); sendByte(8'hA5, 1'b0, 1'b0);
    sendByte(8'hF5, 1'b1, 1'b0);
    chk("R6", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 0));
    sendByte(8'hF5, 1'b1, 1'b1);
    chk("R6", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 1));
    sendStop(); sendByte(8'hF2, 1'b1, 1'b0); sendByte(8'hC3, 1'b0, 1'b0);
    sendByte(8'hF5, 1'b1, 1'b1);
    chk("R6", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 1));
    sendByte(8'hF3, 1'b1, 1'b1);
    chk("R6", got(), mk(1, 1, 1, 0, 0, 2'b10, 1, 1, 1));
    sendStop(); sendByte(8'hF4, 1'b1, 1'b0); sendByte(8'hA5, 1'b0, 1'b0);
    sendStop();
    chk("R2", {stopFlag, respValid}, 2'b10);
    sendByte(8'hF5, 1'b1, 1'b1);
    chk("R6", got(), mk(1, 0, 0, 0, 0, 2'b00, 0, 1, 1));
    @(negedge clk);
    chk("R2", {got(), stopFlag}, '0);

    finish();
  end
endmodule